// File: doc/BRIEF.md
# Hypervisor Trap Detail Registers

This block keeps the four registers that give trap handlers extra detail beyond the main trap value and cause registers. There is one pair for traps taken into the hypervisor-supervisor level (HS) and one pair for traps taken into machine level (M). Each pair holds a second trap value, which is the guest physical address of a guest-page fault shifted right by two, and a trap instruction word, which is the transformed form of the instruction that trapped.

A trap event updates only the pair of the level it targets. The block captures whatever guest physical address the translation logic supplies. For a fault on an implicit page-table access, that is the address of the entry. For an access that faults only in part, it is the address of the faulting portion. Software reads and writes the registers through a 12-bit CSR address port.

Each register can be configured away, in which case it reads as zero and ignores writes. The width is set by `XLEN` (32 or 64).

Top module: `hvt_trap_csrs`

## Requirements
- R1: After synchronous reset all four registers read zero.
- R2: A trap whose cause is a guest-page fault (20 instruction, 21 load, 23 store/AMO) and whose `trap_gpa_ok` is 1 writes bits [XLEN+1:2] of `trap_gpa` into the target level's second trap value register, visible on the cycle after the event.
- R3: A guest-page-fault trap with `trap_gpa_ok` at 0 writes zero into the target level's second trap value register.
- R4: A trap with any other cause writes zero into the target level's second trap value register.
- R5: Every trap writes `trap_tinst` into the target level's trap instruction register.
- R6: A trap leaves the pair of the other level unchanged (`trap_level` 0 selects HS, 1 selects M).
- R7: When a trap and a CSR write hit the same register in one cycle, the trap value wins.
- R8: With no trap to its level, a CSR write loads `csr_wdata` into the addressed register, visible the next cycle. The addresses are 0x643 (HS second value), 0x64A (HS instruction), 0x34B (M second value) and 0x34A (M instruction). `csr_rdata` shows the addressed register combinationally.
- R9: Reads of any other address return zero, and writes to it change no register.
- R10: A register disabled by its parameter always reads zero, whatever the traps and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_level | input | 1 | Target level: 0 HS, 1 M |
| trap_cause | input | 6 | Exception cause code |
| trap_gpa_ok | input | 1 | Faulting guest physical address is known |
| trap_gpa | input | GPA_W | Faulting guest physical address |
| trap_tinst | input | XLEN | Transformed instruction word |
| csr_addr | input | 12 | CSR address for read and write |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for csr_addr |

## Verification
The assertions assume that `trap_valid` is the only qualifier on the trap fields. Cause, level and address may hold any value while it is low, and the properties only inspect them in cycles where it is high. They also assume that `csr_addr` is stable for a whole cycle, so that a write and the read on the same cycle refer to the same register. The stimulus changes every input only at the falling edge. It mixes legal addresses with one unmapped address and guest-page-fault causes with ordinary ones, and it deliberately places traps and CSR writes to the same register in the same cycle.

// File: rtl/hvt_pkg.sv
package hvt_pkg;

    typedef enum logic {
        LVL_HS = 1'b0,
        LVL_M  = 1'b1
    } trap_lvl_e;

    localparam logic [11:0] ADDR_HS_VAL2  = 12'h643;
    localparam logic [11:0] ADDR_HS_TINST = 12'h64A;
    localparam logic [11:0] ADDR_M_VAL2   = 12'h34B;
    localparam logic [11:0] ADDR_M_TINST  = 12'h34A;

    localparam logic [5:0] CAUSE_GPF_FETCH = 6'd20;
    localparam logic [5:0] CAUSE_GPF_LOAD  = 6'd21;
    localparam logic [5:0] CAUSE_GPF_STORE = 6'd23;

    localparam int NUM_LVL = 2;

    typedef struct packed {
        logic      valid;
        trap_lvl_e lvl;
        logic [5:0] cause;
        logic      gpa_ok;
    } trap_ctl_t;

    function automatic logic is_guest_fault(logic [5:0] cause);
        return (cause == CAUSE_GPF_FETCH) || (cause == CAUSE_GPF_LOAD) ||
               (cause == CAUSE_GPF_STORE);
    endfunction

    function automatic logic [11:0] val2_addr(trap_lvl_e lvl);
        return (lvl == LVL_M) ? ADDR_M_VAL2 : ADDR_HS_VAL2;
    endfunction

    function automatic logic [11:0] tinst_addr(trap_lvl_e lvl);
        return (lvl == LVL_M) ? ADDR_M_TINST : ADDR_HS_TINST;
    endfunction

endpackage

// File: rtl/hvt_gpa_align.sv
module hvt_gpa_align #(
    parameter int XLEN  = 64,
    parameter int GPA_W = XLEN + 2
) (
    input  logic [GPA_W-1:0] gpa,
    output logic [XLEN-1:0]  gpa_sh
);
    localparam int SH_W = GPA_W - 2;

    generate
        if (SH_W >= XLEN) begin : g_trunc
            assign gpa_sh = gpa[XLEN+1:2];
            if (GPA_W > XLEN + 2) begin : g_drop
                logic unused_hi;
                assign unused_hi = ^gpa[GPA_W-1:XLEN+2];
            end
        end else begin : g_ext
            assign gpa_sh = {{(XLEN-SH_W){1'b0}}, gpa[GPA_W-1:2]};
        end
    endgenerate

    logic unused_lo;
    assign unused_lo = ^gpa[1:0];
endmodule

// File: rtl/hvt_lvl_pair.sv
module hvt_lvl_pair
    import hvt_pkg::*;
#(
    parameter int        XLEN       = 64,
    parameter trap_lvl_e LVL        = LVL_HS,
    parameter bit        REPORT_GPA = 1'b1,
    parameter bit        KEEP_TINST = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  trap_ctl_t       ctl,
    input  logic [XLEN-1:0] gpa_sh,
    input  logic [XLEN-1:0] tinst,
    input  logic [11:0]     csr_addr,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] val2_q,
    output logic [XLEN-1:0] tinst_q,
    output logic [XLEN-1:0] rd_data
);
    localparam logic [11:0] V2_ADDR = val2_addr(LVL);
    localparam logic [11:0] TI_ADDR = tinst_addr(LVL);

    logic trap_here;
    logic wr_v2;
    logic wr_ti;
    logic [XLEN-1:0] v2_capture;

    assign trap_here  = ctl.valid && (ctl.lvl == LVL);
    assign wr_v2      = csr_we && (csr_addr == V2_ADDR);
    assign wr_ti      = csr_we && (csr_addr == TI_ADDR);
    assign v2_capture = (is_guest_fault(ctl.cause) && ctl.gpa_ok) ? gpa_sh : '0;

    generate
        if (REPORT_GPA) begin : g_v2
            always_ff @(posedge clk) begin
                if (rst)            val2_q <= '0;
                else if (trap_here) val2_q <= v2_capture;
                else if (wr_v2)     val2_q <= csr_wdata;
            end
        end else begin : g_v2_zero
            assign val2_q = '0;
        end

        if (KEEP_TINST) begin : g_ti
            always_ff @(posedge clk) begin
                if (rst)            tinst_q <= '0;
                else if (trap_here) tinst_q <= tinst;
                else if (wr_ti)     tinst_q <= csr_wdata;
            end
        end else begin : g_ti_zero
            assign tinst_q = '0;
        end
    endgenerate

    always_comb begin
        if (csr_addr == V2_ADDR)      rd_data = val2_q;
        else if (csr_addr == TI_ADDR) rd_data = tinst_q;
        else                          rd_data = '0;
    end
endmodule

// File: rtl/hvt_trap_csrs.sv
module hvt_trap_csrs
    import hvt_pkg::*;
#(
    parameter int XLEN          = 64,
    parameter int GPA_W         = XLEN + 2,
    parameter bit REPORT_GPA_HS = 1'b1,
    parameter bit REPORT_GPA_M  = 1'b1,
    parameter bit KEEP_TINST_HS = 1'b1,
    parameter bit KEEP_TINST_M  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_valid,
    input  logic             trap_level,
    input  logic [5:0]       trap_cause,
    input  logic             trap_gpa_ok,
    input  logic [GPA_W-1:0] trap_gpa,
    input  logic [XLEN-1:0]  trap_tinst,
    input  logic [11:0]      csr_addr,
    input  logic             csr_we,
    input  logic [XLEN-1:0]  csr_wdata,
    output logic [XLEN-1:0]  csr_rdata
);
    trap_ctl_t ctl;
    logic [XLEN-1:0] gpa_sh;
    logic [NUM_LVL-1:0][XLEN-1:0] val2_q;
    logic [NUM_LVL-1:0][XLEN-1:0] tinst_q;
    logic [NUM_LVL-1:0][XLEN-1:0] pair_rd;

    assign ctl.valid  = trap_valid;
    assign ctl.lvl    = trap_lvl_e'(trap_level);
    assign ctl.cause  = trap_cause;
    assign ctl.gpa_ok = trap_gpa_ok;

    hvt_gpa_align #(.XLEN(XLEN), .GPA_W(GPA_W)) align_i (
        .gpa    (trap_gpa),
        .gpa_sh (gpa_sh)
    );

    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
        hvt_lvl_pair #(
            .XLEN       (XLEN),
            .LVL        (trap_lvl_e'(1'(i))),
            .REPORT_GPA ((i == 0) ? REPORT_GPA_HS : REPORT_GPA_M),
            .KEEP_TINST ((i == 0) ? KEEP_TINST_HS : KEEP_TINST_M)
        ) pair_i (
            .clk       (clk),
            .rst       (rst),
            .ctl       (ctl),
            .gpa_sh    (gpa_sh),
            .tinst     (trap_tinst),
            .csr_addr  (csr_addr),
            .csr_we    (csr_we),
            .csr_wdata (csr_wdata),
            .val2_q    (val2_q[i]),
            .tinst_q   (tinst_q[i]),
            .rd_data   (pair_rd[i])
        );
    end

    always_comb begin
        csr_rdata = '0;
        for (int i = 0; i < NUM_LVL; i++) csr_rdata |= pair_rd[i];
    end
endmodule

// File: rtl/hvt_trap_csrs_chk.sv
module hvt_trap_csrs_chk
    import hvt_pkg::*;
#(
    parameter int XLEN          = 64,
    parameter bit REPORT_GPA_HS = 1'b1,
    parameter bit REPORT_GPA_M  = 1'b1,
    parameter bit KEEP_TINST_M  = 1'b1
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         trap_valid,
    input logic                         trap_level,
    input logic [5:0]                   trap_cause,
    input logic                         trap_gpa_ok,
    input logic [XLEN-1:0]              gpa_sh,
    input logic [XLEN-1:0]              trap_tinst,
    input logic [11:0]                  csr_addr,
    input logic                         csr_we,
    input logic [XLEN-1:0]              csr_rdata,
    input logic [NUM_LVL-1:0][XLEN-1:0] val2_q,
    input logic [NUM_LVL-1:0][XLEN-1:0] tinst_q
);
    logic known_addr;
    logic m_addr;
    assign known_addr = (csr_addr == ADDR_HS_VAL2) || (csr_addr == ADDR_HS_TINST) ||
                        (csr_addr == ADDR_M_VAL2)  || (csr_addr == ADDR_M_TINST);
    assign m_addr     = (csr_addr == ADDR_M_VAL2)  || (csr_addr == ADDR_M_TINST);

    AST_GPF_CAPTURE_M: assert property (@(posedge clk) disable iff (rst)
        (REPORT_GPA_M && trap_valid && trap_level && is_guest_fault(trap_cause) && trap_gpa_ok)
        |=> (val2_q[1] == $past(gpa_sh))); // R2

    AST_GPF_NOADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && is_guest_fault(trap_cause) && !trap_gpa_ok)
        |=> (val2_q[$past(trap_level)] == '0)); // R3

    AST_OTHER_CAUSE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && !is_guest_fault(trap_cause))
        |=> (val2_q[$past(trap_level)] == '0)); // R4

    AST_HS_TRAP_KEEPS_M: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && !trap_level && !(csr_we && m_addr))
        |=> ($stable(val2_q[1]) && $stable(tinst_q[1]))); // R6

    AST_TRAP_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (KEEP_TINST_M && trap_valid && trap_level && csr_we && (csr_addr == ADDR_M_TINST))
        |=> (tinst_q[1] == $past(trap_tinst))); // R7

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !known_addr |-> (csr_rdata == '0)); // R9

    AST_HS_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!REPORT_GPA_HS && (csr_addr == ADDR_HS_VAL2)) |-> (csr_rdata == '0)); // R10
endmodule

bind hvt_trap_csrs hvt_trap_csrs_chk #(
    .XLEN          (XLEN),
    .REPORT_GPA_HS (REPORT_GPA_HS),
    .REPORT_GPA_M  (REPORT_GPA_M),
    .KEEP_TINST_M  (KEEP_TINST_M)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .trap_valid  (trap_valid),
    .trap_level  (trap_level),
    .trap_cause  (trap_cause),
    .trap_gpa_ok (trap_gpa_ok),
    .gpa_sh      (gpa_sh),
    .trap_tinst  (trap_tinst),
    .csr_addr    (csr_addr),
    .csr_we      (csr_we),
    .csr_rdata   (csr_rdata),
    .val2_q      (val2_q),
    .tinst_q     (tinst_q)
);

// File: tb/hvt_trap_csrs_tb.sv
module hvt_trap_csrs_tb_top;
    localparam int XLEN  = 64;
    localparam int GPA_W = XLEN + 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trap_valid = 1'b0;
    logic             trap_level = 1'b0;
    logic [5:0]       trap_cause = '0;
    logic             trap_gpa_ok = 1'b0;
    logic [GPA_W-1:0] trap_gpa = '0;
    logic [XLEN-1:0]  trap_tinst = '0;
    logic [11:0]      csr_addr = '0;
    logic             csr_we = 1'b0;
    logic [XLEN-1:0]  csr_wdata = '0;
    logic [XLEN-1:0]  csr_rdata;
    logic [31:0]      ro_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference state: index 0 HS val2, 1 HS tinst, 2 M val2, 3 M tinst
    logic [XLEN-1:0] ref_q [4];

    always #5 clk = ~clk;

    hvt_trap_csrs #(.XLEN(XLEN), .GPA_W(GPA_W)) dut_i (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_level(trap_level),
        .trap_cause(trap_cause), .trap_gpa_ok(trap_gpa_ok), .trap_gpa(trap_gpa),
        .trap_tinst(trap_tinst), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
    );

    hvt_trap_csrs #(.XLEN(32), .GPA_W(34), .REPORT_GPA_HS(1'b0), .REPORT_GPA_M(1'b0),
                    .KEEP_TINST_HS(1'b0), .KEEP_TINST_M(1'b0)) dut_ro_i (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_level(trap_level),
        .trap_cause(trap_cause), .trap_gpa_ok(trap_gpa_ok), .trap_gpa(trap_gpa[33:0]),
        .trap_tinst(trap_tinst[31:0]), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata[31:0]), .csr_rdata(ro_rdata)
    );

    function automatic int slot(logic [11:0] a);
        case (a)
            12'h643: return 0;
            12'h64A: return 1;
            12'h34B: return 2;
            12'h34A: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic bit gfault(logic [5:0] c);
        return (c == 6'd20) || (c == 6'd21) || (c == 6'd23);
    endfunction

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at the falling edge, compare the read of
    // csr_addr against the reference, then advance the reference.
    task automatic step(input string tag, input bit tv, input bit lvl, input logic [5:0] cause,
                        input bit gok, input logic [GPA_W-1:0] gpa, input logic [XLEN-1:0] ti,
                        input logic [11:0] addr, input bit we, input logic [XLEN-1:0] wd);
        int s;
        int base;
        @(negedge clk);
        trap_valid = tv; trap_level = lvl; trap_cause = cause; trap_gpa_ok = gok;
        trap_gpa = gpa; trap_tinst = ti; csr_addr = addr; csr_we = we; csr_wdata = wd;
        #1;
        s = slot(addr);
        check(tag, csr_rdata, (s < 0) ? '0 : ref_q[s]);
        check("R10", {32'h0, ro_rdata}, '0);
        if (we && s >= 0) ref_q[s] = wd;
        if (tv) begin
            base = lvl ? 2 : 0;
            ref_q[base]     = (gfault(cause) && gok) ? gpa[XLEN+1:2] : '0;
            ref_q[base + 1] = ti;
        end
    endtask

    task automatic idle_read(input string tag, input logic [11:0] addr);
        step(tag, 1'b0, 1'b0, 6'd0, 1'b0, '0, '0, addr, 1'b0, '0);
    endtask

    localparam logic [GPA_W-1:0] GPA_A = 66'h2_1234_5678_9ABC_DEF4;
    localparam logic [GPA_W-1:0] GPA_B = 66'h0_0000_00F0_0000_1008;

    initial begin
        for (int i = 0; i < 4; i++) ref_q[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset contents
        idle_read("R1", 12'h643);
        idle_read("R1", 12'h64A);
        idle_read("R1", 12'h34B);
        idle_read("R1", 12'h34A);
        // R7: trap and write to the same M registers in one cycle
        step("R8", 1'b1, 1'b1, 6'd21, 1'b1, GPA_A, 64'hAAAA_0000_1111_2222,
             12'h34B, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        idle_read("R7", 12'h34B);
        idle_read("R2", 12'h34B);
        idle_read("R5", 12'h34A);
        idle_read("R6", 12'h643);
        // R8: plain CSR writes to the HS pair
        step("R8", 1'b0, 1'b0, 6'd0, 1'b0, '0, '0, 12'h643, 1'b1, 64'h55);
        step("R8", 1'b0, 1'b0, 6'd0, 1'b0, '0, '0, 12'h64A, 1'b1, 64'h66);
        idle_read("R8", 12'h643);
        idle_read("R8", 12'h64A);
        // R3: guest fault without a known address
        step("R8", 1'b1, 1'b0, 6'd20, 1'b0, GPA_B, 64'h0000_0000_0000_3073, 12'h643, 1'b0, '0);
        idle_read("R3", 12'h643);
        idle_read("R6", 12'h34B);
        idle_read("R6", 12'h34A);
        // R4: ordinary cause clears second value
        step("R8", 1'b0, 1'b0, 6'd0, 1'b0, '0, '0, 12'h643, 1'b1, 64'h77);
        step("R8", 1'b1, 1'b0, 6'd13, 1'b1, GPA_B, 64'h0000_0000_0000_0003, 12'h643, 1'b0, '0);
        idle_read("R4", 12'h643);
        idle_read("R5", 12'h64A);
        // R9: unmapped address
        step("R9", 1'b0, 1'b0, 6'd0, 1'b0, '0, '0, 12'h340, 1'b1, 64'hDEAD_BEEF);
        idle_read("R9", 12'h340);
        idle_read("R9", 12'h643);
        idle_read("R9", 12'h34A);
        // R2: store guest fault into HS
        step("R8", 1'b1, 1'b0, 6'd23, 1'b1, GPA_B, 64'h0000_0000_0000_2023, 12'h643, 1'b0, '0);
        idle_read("R2", 12'h643);
        // mixed stimulus against the reference model
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] a;
            logic [5:0]  c;
            int r;
            r = $urandom_range(0, 4);
            a = (r == 0) ? 12'h643 : (r == 1) ? 12'h64A : (r == 2) ? 12'h34B :
                (r == 3) ? 12'h34A : 12'h340;
            r = $urandom_range(0, 5);
            c = (r == 0) ? 6'd20 : (r == 1) ? 6'd21 : (r == 2) ? 6'd23 : 6'($urandom_range(0, 24));
            step((slot(a) < 0) ? "R9" : "R8", ($urandom_range(0, 2) == 0), 1'($urandom),
                 c, 1'($urandom), {2'($urandom), $urandom, $urandom}, {$urandom, $urandom},
                 a, ($urandom_range(0, 1) == 0), {$urandom, $urandom});
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule